// File: doc/BRIEF.md
# Floating-Point Issue Scheduler with Adder Stage Reservation

This block decides, in the same cycle as a request, whether the next floating-point operation may start on one of three shared execution units: an adder, a multiplier and a divider that also runs square roots. A request names an operation class and a precision. The answer is a grant or a stall. A stalled request is simply held by the requester and presented again later.

The adder is the contested resource. Multiplies borrow its mantissa-add and rounding stages for their final cleanup, and divides and square roots borrow it for one preparation cycle and for several cleanup cycles. The scheduler keeps one shift-register reservation track per adder resource: the adder body, the mantissa-add stage and the round stage. On every request it tests the operation's usage pattern against these tracks, and a grant merges that pattern into them. Busy counters for the divider and for the multiplier's two in-flight slots apply the occupancy limits of each unit.

Latencies for multiply, divide and square root are parameters, each with a single-precision and a double-precision value. A unit counts as free again in the last cycle of its current operation.

Top module: `fpu_issue_sched`

## Requirements
- R1: `op_class` encodes 0 = add/subtract, 1 = compare, 2 = multiply, 3 = divide, 4 = square root, 5 = convert/negate/absolute. Codes 6 and 7 are reserved and are never granted. `is_double` = 1 selects the double-precision latency.
- R2: `grant` is combinational from the current request and state, and is never high without `req_valid`. `stall` is high exactly when `req_valid` is high and `grant` is low.
- R3: `rst` is synchronous and active high. While it is high `grant` stays low. After it falls, every busy counter and reservation is empty, so any legal first request is granted.
- R4: An add/subtract occupies the adder body for its first three cycles. Another add granted at cycle t stalls a new add at t+1 and t+2 and allows one at t+3.
- R5: The divider holds one divide or square root at a time. After a divider grant at t with latency L, the next divider request is granted no earlier than t+L-1, the final cycle of the earlier operation.
- R6: Multiplies are never granted in two consecutive cycles, and at most two multiplies are in flight, counting any multiply that is not in its final cycle.
- R7: A multiply of latency L granted at t uses the adder's mantissa-add stage at t+L-2 and its round stage at t+L-1. An add at k uses mantissa-add at k+1 and k+2 and round at k+2 and k+3. It stalls on any overlap and is granted otherwise.
- R8: A compare uses the body at offsets 0 and 1, mantissa-add at offset 1 and round at offset 2. It also stalls when any mantissa-add or round reservation lies within offsets 0 to 2 of its issue cycle, even without a stage overlap.
- R9: A divide or square root of latency L holds the adder body at offset 0 and at L-3 and L-2, mantissa-add at L-3 and L-2, and round at L-2 and L-1. An adder-class operation may start at t+1, right after the preparation cycle, and at t+L-1, the last cleanup cycle.
- R10: Convert/negate/absolute occupies the adder body for two cycles, so a second one stalls at t+1 and is granted at t+2.
- R11: A stalled request changes no reservation, counter or back-to-back state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An issue request is present |
| op_class | input | 3 | Operation class of the request (R1 encoding) |
| is_double | input | 1 | 1 = double precision, 0 = single |
| grant | output | 1 | Request issues this cycle |
| stall | output | 1 | Request is present but held back |

## Verification
The bench builds the block with multiply latencies 4/6, divide 8/10 and square root 12/14, and with the strict compare guard enabled. With these short windows every collision, overlap and release cycle falls within about a dozen cycles of the first grant, so each stall and grant can be timed by hand. The double-precision multiply latency of 6 exceeds two issue spacings, which lets a third multiply at t+4 reach the two-in-flight cap and be released one cycle later. The divider latencies make the cleanup window at L-3 to L-2 and the final-cycle release at L-1 land on separate, distinguishable cycles.

// File: rtl/fpu_sched_pkg.sv
package fpu_sched_pkg;

   localparam logic [2:0] OP_ADD  = 3'd0;
   localparam logic [2:0] OP_CMP  = 3'd1;
   localparam logic [2:0] OP_MUL  = 3'd2;
   localparam logic [2:0] OP_DIV  = 3'd3;
   localparam logic [2:0] OP_SQRT = 3'd4;
   localparam logic [2:0] OP_CVT  = 3'd5;

   // reservation track indices
   localparam int TRK_BODY  = 0;
   localparam int TRK_MADD  = 1;
   localparam int TRK_ROUND = 2;
   localparam int NUM_TRK   = 3;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fpu_op_pattern.sv
module fpu_op_pattern
   import fpu_sched_pkg::*;
#(
   parameter int RW     = 16,
   parameter int CW     = 5,
   parameter int MUL_S  = 7,
   parameter int MUL_D  = 8,
   parameter int DIV_S  = 23,
   parameter int DIV_D  = 36,
   parameter int SQRT_S = 54,
   parameter int SQRT_D = 112
) (
   input  logic [2:0]    op_class,
   input  logic          is_double,
   output logic [RW-1:0] pat_body,
   output logic [RW-1:0] pat_madd,
   output logic [RW-1:0] pat_round,
   output logic [RW-1:0] pat_guard,
   output logic          use_mul,
   output logic          use_div,
   output logic          legal,
   output logic [CW-1:0] lat
);
   localparam logic [RW-1:0] ONE     = RW'(1);
   localparam logic [RW-1:0] ADD_B   = RW'(7);
   localparam logic [RW-1:0] ADD_M   = RW'(6);
   localparam logic [RW-1:0] ADD_R   = RW'(12);
   localparam logic [RW-1:0] CMP_B   = RW'(3);
   localparam logic [RW-1:0] CMP_M   = RW'(2);
   localparam logic [RW-1:0] CMP_R   = RW'(4);
   localparam logic [RW-1:0] CMP_G   = RW'(7);
   localparam logic [RW-1:0] CVT_B   = RW'(3);
   localparam logic [CW-1:0] L_MS    = CW'(MUL_S);
   localparam logic [CW-1:0] L_MD    = CW'(MUL_D);
   localparam logic [CW-1:0] L_DS    = CW'(DIV_S);
   localparam logic [CW-1:0] L_DD    = CW'(DIV_D);
   localparam logic [CW-1:0] L_QS    = CW'(SQRT_S);
   localparam logic [CW-1:0] L_QD    = CW'(SQRT_D);

   always_comb begin
      pat_body  = '0;
      pat_madd  = '0;
      pat_round = '0;
      pat_guard = '0;
      use_mul   = 1'b0;
      use_div   = 1'b0;
      legal     = 1'b1;
      lat       = '0;
      case (op_class)
         OP_ADD: begin
            pat_body  = ADD_B;
            pat_madd  = ADD_M;
            pat_round = ADD_R;
         end
         OP_CMP: begin
            pat_body  = CMP_B;
            pat_madd  = CMP_M;
            pat_round = CMP_R;
            pat_guard = CMP_G;
         end
         OP_CVT: begin
            pat_body  = CVT_B;
         end
         OP_MUL: begin
            use_mul   = 1'b1;
            lat       = is_double ? L_MD : L_MS;
            pat_madd  = ONE << (lat - CW'(2));
            pat_round = ONE << (lat - CW'(1));
         end
         OP_DIV, OP_SQRT: begin
            use_div   = 1'b1;
            if (op_class == OP_SQRT) lat = is_double ? L_QD : L_QS;
            else                     lat = is_double ? L_DD : L_DS;
            pat_body  = ONE | (ONE << (lat - CW'(3))) | (ONE << (lat - CW'(2)));
            pat_madd  = (ONE << (lat - CW'(3))) | (ONE << (lat - CW'(2)));
            pat_round = (ONE << (lat - CW'(2))) | (ONE << (lat - CW'(1)));
         end
         default: legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/fpu_resv_table.sv
module fpu_resv_table #(
   parameter int RW = 16,
   parameter int NT = 3
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [NT-1:0][RW-1:0]  pat,
   input  logic                   commit,
   output logic [NT-1:0][RW-1:0]  occ,
   output logic [NT-1:0]          clash
);
   for (genvar t = 0; t < NT; t++) begin : g_trk
      logic [RW-1:0] occ_q;

      always_ff @(posedge clk) begin
         if (rst) occ_q <= '0;
         else     occ_q <= (occ_q | (commit ? pat[t] : '0)) >> 1;
      end

      assign occ[t]   = occ_q;
      assign clash[t] = |(occ_q & pat[t]);
   end

endmodule

// File: rtl/fpu_busy_counter.sv
module fpu_busy_counter #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] lat,
   output logic          idle
);
   logic [CW-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (rst)                 remain_q <= '0;
      else if (load)           remain_q <= lat - CW'(1);
      else if (remain_q != '0) remain_q <= remain_q - CW'(1);
   end

   // final execution cycle counts as free
   assign idle = (remain_q <= CW'(1));

endmodule

// File: rtl/fpu_mul_slots.sv
module fpu_mul_slots #(
   parameter int NS = 2,
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          issue,
   input  logic [CW-1:0] lat,
   output logic          mul_ok
);
   logic [NS-1:0] slot_free;
   logic [NS-1:0] pick;
   logic          taken;
   logic          last_q;

   always_comb begin
      pick  = '0;
      taken = 1'b0;
      for (int i = 0; i < NS; i++) begin
         if (slot_free[i] && !taken) begin
            pick[i] = 1'b1;
            taken   = 1'b1;
         end
      end
   end

   for (genvar i = 0; i < NS; i++) begin : g_slot
      fpu_busy_counter #(.CW(CW)) u_cnt (
         .clk  (clk),
         .rst  (rst),
         .load (issue && pick[i]),
         .lat  (lat),
         .idle (slot_free[i])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= issue;
   end

   assign mul_ok = (|slot_free) && !last_q;

endmodule

// File: rtl/fpu_issue_sched.sv
module fpu_issue_sched
   import fpu_sched_pkg::*;
#(
   parameter int MUL_LAT_S  = 7,
   parameter int MUL_LAT_D  = 8,
   parameter int DIV_LAT_S  = 23,
   parameter int DIV_LAT_D  = 36,
   parameter int SQRT_LAT_S = 54,
   parameter int SQRT_LAT_D = 112,
   parameter int MUL_SLOTS  = 2,
   parameter bit CMP_STRICT = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       req_valid,
   input  logic [2:0] op_class,
   input  logic       is_double,
   output logic       grant,
   output logic       stall
);
   localparam int MAX_MUL = max_i(MUL_LAT_S, MUL_LAT_D);
   localparam int MAX_DIV = max_i(max_i(DIV_LAT_S, DIV_LAT_D),
                                  max_i(SQRT_LAT_S, SQRT_LAT_D));
   localparam int MAX_LAT = max_i(MAX_MUL, MAX_DIV);
   localparam int RES_W   = max_i(MAX_LAT, 4);
   localparam int CNT_W   = $clog2(MAX_LAT + 1);

   if (MUL_LAT_S < 3 || MUL_LAT_D < 3) begin : g_bad_mul
      $error("multiply latency must be at least 3");
   end
   if (DIV_LAT_S < 4 || DIV_LAT_D < 4 || SQRT_LAT_S < 4 || SQRT_LAT_D < 4) begin : g_bad_div
      $error("divider latency must be at least 4");
   end
   if (MUL_SLOTS < 1) begin : g_bad_slots
      $error("at least one multiply slot is required");
   end

   logic [RES_W-1:0]                pat_body, pat_madd, pat_round, pat_guard;
   logic                            use_mul, use_div, legal;
   logic [CNT_W-1:0]                lat;
   logic [NUM_TRK-1:0][RES_W-1:0]   pat_all, occ;
   logic [NUM_TRK-1:0]              clash;
   logic                            mul_ok, div_idle, guard_hit, issue_ok;

   fpu_op_pattern #(
      .RW(RES_W), .CW(CNT_W),
      .MUL_S(MUL_LAT_S), .MUL_D(MUL_LAT_D),
      .DIV_S(DIV_LAT_S), .DIV_D(DIV_LAT_D),
      .SQRT_S(SQRT_LAT_S), .SQRT_D(SQRT_LAT_D)
   ) u_pat (
      .op_class  (op_class),
      .is_double (is_double),
      .pat_body  (pat_body),
      .pat_madd  (pat_madd),
      .pat_round (pat_round),
      .pat_guard (pat_guard),
      .use_mul   (use_mul),
      .use_div   (use_div),
      .legal     (legal),
      .lat       (lat)
   );

   assign pat_all[TRK_BODY]  = pat_body;
   assign pat_all[TRK_MADD]  = pat_madd;
   assign pat_all[TRK_ROUND] = pat_round;

   fpu_resv_table #(.RW(RES_W), .NT(NUM_TRK)) u_resv (
      .clk    (clk),
      .rst    (rst),
      .pat    (pat_all),
      .commit (grant),
      .occ    (occ),
      .clash  (clash)
   );

   fpu_mul_slots #(.NS(MUL_SLOTS), .CW(CNT_W)) u_mul (
      .clk    (clk),
      .rst    (rst),
      .issue  (grant && use_mul),
      .lat    (lat),
      .mul_ok (mul_ok)
   );

   fpu_busy_counter #(.CW(CNT_W)) u_div (
      .clk  (clk),
      .rst  (rst),
      .load (grant && use_div),
      .lat  (lat),
      .idle (div_idle)
   );

   if (CMP_STRICT) begin : g_cmp_strict
      assign guard_hit = |(pat_guard & (occ[TRK_MADD] | occ[TRK_ROUND]));
   end else begin : g_cmp_loose
      assign guard_hit = 1'b0;
   end

   assign issue_ok = legal && !(|clash) && !guard_hit
                   && (!use_mul || mul_ok) && (!use_div || div_idle);

   assign grant = !rst && req_valid && issue_ok;
   assign stall = req_valid && !grant;

endmodule

// File: rtl/fpu_issue_sched_chk.sv
module fpu_issue_sched_chk
   import fpu_sched_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       req_valid,
   input logic [2:0] op_class,
   input logic       grant,
   input logic       stall
);
   logic       add_go, mul_go, div_go;
   logic [1:0] div_gap_q;

   assign add_go = grant && (op_class == OP_ADD);
   assign mul_go = grant && (op_class == OP_MUL);
   assign div_go = grant && ((op_class == OP_DIV) || (op_class == OP_SQRT));

   always_ff @(posedge clk) begin
      if (rst)                 div_gap_q <= 2'd3;
      else if (div_go)         div_gap_q <= 2'd1;
      else if (div_gap_q != 3) div_gap_q <= div_gap_q + 2'd1;
   end

   // R2
   grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
      grant |-> req_valid);

   // R2
   grant_stall_excl_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> (grant != stall));

   // R2
   stall_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
      !req_valid |-> !stall);

   // R1
   rsvd_never_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && op_class > OP_CVT) |-> !grant);

   // R3
   rst_no_grant_chk: assert property (@(posedge clk)
      rst |-> !grant);

   // R6
   mul_b2b_chk: assert property (@(posedge clk) disable iff (rst)
      mul_go |=> !mul_go);

   // R4
   add_rep1_chk: assert property (@(posedge clk) disable iff (rst)
      add_go |=> !add_go);

   // R4
   add_rep2_chk: assert property (@(posedge clk) disable iff (rst)
      add_go |=> ##1 !add_go);

   // R5
   div_gap_chk: assert property (@(posedge clk) disable iff (rst)
      div_go |-> (div_gap_q == 2'd3));

endmodule

bind fpu_issue_sched fpu_issue_sched_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .op_class  (op_class),
   .grant     (grant),
   .stall     (stall)
);

// File: tb/fpu_issue_sched_tb.sv
module fpu_issue_sched_tb;
   import fpu_sched_pkg::*;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req_valid = 1'b0;
   logic [2:0] op_class = 3'd0;
   logic       is_double = 1'b0;
   logic       grant, stall;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   fpu_issue_sched #(
      .MUL_LAT_S(4), .MUL_LAT_D(6),
      .DIV_LAT_S(8), .DIV_LAT_D(10),
      .SQRT_LAT_S(12), .SQRT_LAT_D(14),
      .MUL_SLOTS(2), .CMP_STRICT(1'b1)
   ) u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid),
      .op_class(op_class), .is_double(is_double),
      .grant(grant), .stall(stall)
   );

   // one cycle: drive after the falling edge, sample 1 ns later
   task automatic cyc(input logic v, input logic [2:0] op, input logic d,
                      input logic eg, input string tag);
      logic es;
      @(negedge clk);
      req_valid = v;
      op_class  = op;
      is_double = d;
      #1;
      es = v && !eg;
      checks++;
      if (grant !== eg || stall !== es) begin
         errors++;
         $display("FAIL %s: grant=%b stall=%b expected grant=%b stall=%b",
                  tag, grant, stall, eg, es);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      cyc(1'b0, OP_ADD, 1'b0, 1'b0, "R2 idle no grant no stall");
      @(negedge clk);
      rst = 1'b1;
      cyc(1'b1, OP_ADD, 1'b0, 1'b0, "R3 no grant during reset");
      rst = 1'b0;
      cyc(1'b1, OP_MUL, 1'b1, 1'b1, "R3 mul after reset");
      do_reset();
      cyc(1'b1, OP_MUL, 1'b1, 1'b1, "R3 mul right after mid-run reset");
      do_reset();
   endtask

   task automatic t_encoding();
      cyc(1'b1, 3'd6, 1'b0, 1'b0, "R1 reserved code 6");
      cyc(1'b1, 3'd7, 1'b1, 1'b0, "R1 reserved code 7");
      cyc(1'b0, OP_ADD, 1'b0, 1'b0, "R2 no request");
      cyc(1'b1, OP_ADD, 1'b0, 1'b1, "R1 add after reserved");
      do_reset();
   endtask

   task automatic t_add_repeat();
      cyc(1'b1, OP_ADD, 1'b0, 1'b1, "R4 add t0");
      cyc(1'b1, OP_ADD, 1'b0, 1'b0, "R4 add t1");
      cyc(1'b1, OP_ADD, 1'b0, 1'b0, "R4 add t2");
      cyc(1'b1, OP_ADD, 1'b1, 1'b1, "R4 add t3");
      do_reset();
   endtask

   task automatic t_mul();
      cyc(1'b1, OP_MUL, 1'b0, 1'b1, "R6 mul t0");
      cyc(1'b1, OP_MUL, 1'b0, 1'b0, "R6 mul back to back");
      cyc(1'b1, OP_MUL, 1'b0, 1'b1, "R11 mul t2 after stall");
      do_reset();
      cyc(1'b1, OP_MUL, 1'b1, 1'b1, "R6 muld t0");
      idle(1);
      cyc(1'b1, OP_MUL, 1'b1, 1'b1, "R6 muld t2");
      idle(1);
      cyc(1'b1, OP_MUL, 1'b1, 1'b0, "R6 third muld t4 cap");
      cyc(1'b1, OP_MUL, 1'b1, 1'b1, "R6 muld t5 slot freed");
      do_reset();
   endtask

   task automatic t_mul_add();
      cyc(1'b1, OP_MUL, 1'b0, 1'b1, "R7 mul t0");
      cyc(1'b1, OP_ADD, 1'b0, 1'b0, "R7 add t1 madd clash");
      cyc(1'b1, OP_ADD, 1'b0, 1'b1, "R11 add t2 after stall");
      do_reset();
      cyc(1'b1, OP_MUL, 1'b1, 1'b1, "R7 muld t0");
      idle(3);
      cyc(1'b1, OP_ADD, 1'b0, 1'b1, "R7 add t4 no clash");
      do_reset();
   endtask

   task automatic t_cmp_guard();
      cyc(1'b1, OP_MUL, 1'b1, 1'b1, "R8 muld t0");
      idle(1);
      cyc(1'b1, OP_CMP, 1'b0, 1'b0, "R8 cmp t2");
      cyc(1'b1, OP_CMP, 1'b0, 1'b0, "R8 cmp t3");
      cyc(1'b1, OP_CMP, 1'b0, 1'b0, "R8 cmp t4 no stage clash");
      cyc(1'b1, OP_CMP, 1'b0, 1'b0, "R8 cmp t5");
      cyc(1'b1, OP_CMP, 1'b1, 1'b1, "R8 cmp t6 clear");
      do_reset();
   endtask

   task automatic t_divider();
      cyc(1'b1, OP_DIV, 1'b0, 1'b1, "R5 div t0");
      cyc(1'b1, OP_DIV, 1'b0, 1'b0, "R5 div t1");
      idle(1);
      cyc(1'b1, OP_SQRT, 1'b0, 1'b0, "R5 sqrt t3 shares divider");
      idle(2);
      cyc(1'b1, OP_DIV, 1'b0, 1'b0, "R5 div t6");
      cyc(1'b1, OP_DIV, 1'b0, 1'b1, "R5 div t7 final cycle");
      do_reset();
      cyc(1'b1, OP_DIV, 1'b1, 1'b1, "R5 divd t0");
      idle(7);
      cyc(1'b1, OP_DIV, 1'b1, 1'b0, "R5 divd t8");
      cyc(1'b1, OP_DIV, 1'b1, 1'b1, "R5 divd t9");
      do_reset();
   endtask

   task automatic t_div_adder();
      cyc(1'b1, OP_DIV, 1'b0, 1'b1, "R9 div t0");
      idle(4);
      cyc(1'b1, OP_ADD, 1'b0, 1'b0, "R9 add t5 cleanup");
      cyc(1'b1, OP_ADD, 1'b0, 1'b0, "R9 add t6 cleanup");
      cyc(1'b1, OP_ADD, 1'b0, 1'b1, "R9 add t7 last cleanup overlap");
      do_reset();
      cyc(1'b1, OP_SQRT, 1'b0, 1'b1, "R9 sqrt t0");
      cyc(1'b1, OP_ADD, 1'b0, 1'b1, "R9 add t1 after prep");
      do_reset();
      cyc(1'b1, OP_ADD, 1'b0, 1'b1, "R9 add t0");
      cyc(1'b1, OP_DIV, 1'b0, 1'b0, "R9 div prep t1");
      cyc(1'b1, OP_DIV, 1'b0, 1'b0, "R9 div prep t2");
      cyc(1'b1, OP_DIV, 1'b0, 1'b1, "R9 div prep t3");
      do_reset();
   endtask

   task automatic t_cvt();
      cyc(1'b1, OP_CVT, 1'b0, 1'b1, "R10 cvt t0");
      cyc(1'b1, OP_CVT, 1'b1, 1'b0, "R10 cvt t1");
      cyc(1'b1, OP_CVT, 1'b1, 1'b1, "R10 cvt t2");
      do_reset();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_encoding();
      t_add_repeat();
      t_mul();
      t_mul_add();
      t_cmp_guard();
      t_divider();
      t_div_adder();
      t_cvt();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule